// File: doc/BRIEF.md
# GPIO Pin Interrupt and Wake Event Detector

This block turns the already-debounced input level of one GPIO pin into two sticky events: an interrupt status bit and a wake status bit. A single configuration word chooses level or edge sensing and the polarity or edge selection. It also holds an interrupt enable, an interrupt unmask bit, one wake enable per sleep state, and the pad output-enable and output-value bits. When software writes the word, it can also clear either status bit by writing one to that bit's position. The same write can change the configuration.

The block compares the wake enables with a sleep-state code from the power controller. The wake status is set only when an event happens while the enabled sleep state is the current one. The status bits, a pending flag and a qualified interrupt line go to the chip-level interrupt summary. The read word shows the configuration, both status bits and the live pin level.

Top module: `gpio_pin_evt`

## Requirements
- R1: After reset, every configuration bit, both status bits, `pad_oe`, `pad_out`, `pending` and `irq_out` are 0.
- R2: A write (`wr_en`=1) loads the configuration on that clock edge. The write-word layout is: bit 0 interrupt enable, bit 1 unmask, bit 2 trigger (1 = level, 0 = edge), bits 4:3 selection, bit 5 output enable, bit 6 output value, bits 7..9 wake enables. From the next cycle, `pad_oe` and `pad_out` follow bits 5 and 6, and `rd_word` shows the stored fields at the same positions.
- R3: In edge mode, selection 01 sets the interrupt status on a rising input and selection 00 on a falling input. The opposite edge has no effect. The status becomes visible one cycle after the sampled change.
- R4: In edge mode, selection 10 sets the status on both rising and falling inputs.
- R5: Selection 11 never sets a status bit in either mode. In level mode, selection 10 never sets a status bit either.
- R6: In level mode, the status sets while the input is at the selected level (01 high, 00 low). A clear write while that level persists leaves it set. After the level goes inactive, a clear write resets it.
- R7: Writing one to bit 10 clears the interrupt status and writing one to bit 11 clears the wake status. In edge mode, a clear on the same edge as a new qualifying edge leaves the status set.
- R8: The interrupt status sets only while the interrupt enable bit is 1.
- R9: `irq_out` is 1 only while the interrupt status, the enable and the unmask bit are all 1. With unmask 0, the status still sets but `irq_out` stays 0.
- R10: The wake status sets on an event when wake enable k (bit 7+k) is 1 and `sleep_state` equals k+1. Sleep state 0 (running) never wakes. The interrupt enable has no effect on the wake status.
- R11: `pending` is 1 exactly when either status bit is 1.
- R12: `rd_word` bit 12 follows the present `pin_in` level without delay. Bits 10 and 11 of `rd_word` show the interrupt and wake status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| pin_in | input | 1 | Debounced pin level |
| sleep_state | input | SLP_W (2) | Current sleep state: 0 run, k+1 selects wake enable k |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | WORD_W-1 (12) | Configuration word with clear-on-one status bits |
| rd_word | output | WORD_W (13) | Configuration, status bits and live pin level |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output value |
| irq_sts | output | 1 | Sticky interrupt status |
| wake_sts | output | 1 | Sticky wake status |
| pending | output | 1 | Either status set |
| irq_out | output | 1 | Enabled and unmasked interrupt |

## Verification
The assertions assume that `pin_in` is already synchronous and debounced, so that each sampled change counts as one genuine edge. They also assume that `sleep_state` changes only between clock edges and holds a legal code. The bench drives every input one time step after the rising edge. It moves `sleep_state` only across the codes 0 to 3. It changes the pin at most once per cycle. Before each new pin pattern it writes the configuration twice, so that no stale edge is scored against a changed selection.

// File: rtl/gpio_pin_evt_pkg.sv
package gpio_pin_evt_pkg;

   typedef enum logic [1:0] {
      SEL_LOW  = 2'b00,
      SEL_HIGH = 2'b01,
      SEL_BOTH = 2'b10,
      SEL_RSVD = 2'b11
   } sel_e;

   typedef struct packed {
      logic irq_en;
      logic unmask;
      logic level;
      sel_e sel;
      logic oe;
      logic oval;
   } pin_cfg_t;

   localparam int B_IRQ_EN  = 0;
   localparam int B_UNMASK  = 1;
   localparam int B_LEVEL   = 2;
   localparam int B_SEL_LO  = 3;
   localparam int B_OE      = 5;
   localparam int B_OVAL    = 6;
   localparam int B_WAKE_LO = 7;

   function automatic int irq_sts_pos(input int n);
      return B_WAKE_LO + n;
   endfunction

   function automatic int wake_sts_pos(input int n);
      return B_WAKE_LO + n + 1;
   endfunction

   function automatic int pin_pos(input int n);
      return B_WAKE_LO + n + 2;
   endfunction

   function automatic int word_w(input int n);
      return B_WAKE_LO + n + 3;
   endfunction

endpackage

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
   import gpio_pin_evt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   input  logic level_mode,
   input  sel_e sel,
   output logic evt
);

   logic prev_q;
   logic rise;
   logic fall;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin_in;
   end

   assign rise = pin_in & ~prev_q;
   assign fall = ~pin_in & prev_q;

   always_comb begin
      evt = 1'b0;
      if (level_mode) begin
         unique case (sel)
            SEL_LOW:  evt = ~pin_in;
            SEL_HIGH: evt = pin_in;
            default:  evt = 1'b0;
         endcase
      end else begin
         unique case (sel)
            SEL_LOW:  evt = fall;
            SEL_HIGH: evt = rise;
            SEL_BOTH: evt = rise | fall;
            default:  evt = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/gpio_wake_match.sv
module gpio_wake_match #(
   parameter int NUM_SLEEP = 3,
   parameter int SLP_W     = 2
) (
   input  logic [SLP_W-1:0]     sleep_state,
   input  logic [NUM_SLEEP-1:0] wake_en,
   output logic                 hit
);

   logic [NUM_SLEEP-1:0] hit_vec;

   for (genvar k = 0; k < NUM_SLEEP; k++) begin : g_state
      assign hit_vec[k] = wake_en[k] && (sleep_state == SLP_W'(k + 1));
   end

   assign hit = |hit_vec;

endmodule

// File: rtl/gpio_w1c_bit.sv
module gpio_w1c_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);

   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= set_i | (q & ~clr_i);
   end

endmodule

// File: rtl/gpio_pin_evt.sv
module gpio_pin_evt
   import gpio_pin_evt_pkg::*;
#(
   parameter  int NUM_SLEEP = 3,
   localparam int SLP_W     = $clog2(NUM_SLEEP + 1),
   localparam int WORD_W    = word_w(NUM_SLEEP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_in,
   input  logic [SLP_W-1:0]  sleep_state,
   input  logic              wr_en,
   input  logic [WORD_W-2:0] wr_data,
   output logic [WORD_W-1:0] rd_word,
   output logic              pad_oe,
   output logic              pad_out,
   output logic              irq_sts,
   output logic              wake_sts,
   output logic              pending,
   output logic              irq_out
);

   localparam int P_IRQ_STS  = irq_sts_pos(NUM_SLEEP);
   localparam int P_WAKE_STS = wake_sts_pos(NUM_SLEEP);
   localparam int P_PIN      = pin_pos(NUM_SLEEP);

   if (NUM_SLEEP < 1 || NUM_SLEEP > 7) begin : g_bad_param
      $error("gpio_pin_evt: NUM_SLEEP must lie in 1..7");
   end

   pin_cfg_t             cfg_q;
   logic [NUM_SLEEP-1:0] wake_en_q;
   logic                 evt;
   logic                 wake_hit;
   logic                 clr_irq;
   logic                 clr_wake;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         wake_en_q <= '0;
      end else if (wr_en) begin
         cfg_q.irq_en <= wr_data[B_IRQ_EN];
         cfg_q.unmask <= wr_data[B_UNMASK];
         cfg_q.level  <= wr_data[B_LEVEL];
         cfg_q.sel    <= sel_e'(wr_data[B_SEL_LO +: 2]);
         cfg_q.oe     <= wr_data[B_OE];
         cfg_q.oval   <= wr_data[B_OVAL];
         wake_en_q    <= wr_data[B_WAKE_LO +: NUM_SLEEP];
      end
   end

   assign clr_irq  = wr_en & wr_data[P_IRQ_STS];
   assign clr_wake = wr_en & wr_data[P_WAKE_STS];

   gpio_evt_detect u_det (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_in     (pin_in),
      .level_mode (cfg_q.level),
      .sel        (cfg_q.sel),
      .evt        (evt)
   );

   gpio_wake_match #(
      .NUM_SLEEP (NUM_SLEEP),
      .SLP_W     (SLP_W)
   ) u_match (
      .sleep_state (sleep_state),
      .wake_en     (wake_en_q),
      .hit         (wake_hit)
   );

   gpio_w1c_bit u_irq_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt & cfg_q.irq_en),
      .clr_i (clr_irq),
      .q     (irq_sts)
   );

   gpio_w1c_bit u_wake_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt & wake_hit),
      .clr_i (clr_wake),
      .q     (wake_sts)
   );

   assign pending = irq_sts | wake_sts;
   assign irq_out = irq_sts & cfg_q.irq_en & cfg_q.unmask;
   assign pad_oe  = cfg_q.oe;
   assign pad_out = cfg_q.oval;

   always_comb begin
      rd_word                         = '0;
      rd_word[B_IRQ_EN]               = cfg_q.irq_en;
      rd_word[B_UNMASK]               = cfg_q.unmask;
      rd_word[B_LEVEL]                = cfg_q.level;
      rd_word[B_SEL_LO +: 2]          = cfg_q.sel;
      rd_word[B_OE]                   = cfg_q.oe;
      rd_word[B_OVAL]                 = cfg_q.oval;
      rd_word[B_WAKE_LO +: NUM_SLEEP] = wake_en_q;
      rd_word[P_IRQ_STS]              = irq_sts;
      rd_word[P_WAKE_STS]             = wake_sts;
      rd_word[P_PIN]                  = pin_in;
   end

endmodule

// File: rtl/gpio_pin_evt_chk.sv
module gpio_pin_evt_chk #(
   parameter  int NUM_SLEEP = 3,
   localparam int SLP_W     = $clog2(NUM_SLEEP + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pin_in,
   input logic [SLP_W-1:0] sleep_state,
   input logic             cfg_irq_en,
   input logic             cfg_unmask,
   input logic             cfg_level,
   input logic [1:0]       cfg_sel,
   input logic             irq_sts,
   input logic             wake_sts,
   input logic             pending,
   input logic             irq_out
);

   // R6
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_level && cfg_sel == 2'b01 && pin_in && cfg_irq_en) |=> irq_sts);

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_sts) |-> $past(cfg_irq_en));

   // R9
   irq_deliv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (irq_sts && cfg_unmask));

   // R10
   wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_state == '0 && !wake_sts) |=> !wake_sts);

   // R11
   pending_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> ($rose(irq_sts) || $rose(wake_sts)));

endmodule

bind gpio_pin_evt gpio_pin_evt_chk #(.NUM_SLEEP(NUM_SLEEP)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pin_in      (pin_in),
   .sleep_state (sleep_state),
   .cfg_irq_en  (rd_word[0]),
   .cfg_unmask  (rd_word[1]),
   .cfg_level   (rd_word[2]),
   .cfg_sel     (rd_word[4:3]),
   .irq_sts     (irq_sts),
   .wake_sts    (wake_sts),
   .pending     (pending),
   .irq_out     (irq_out)
);

// File: tb/gpio_pin_evt_test.sv
module gpio_pin_evt_test;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        pin_in;
   logic [1:0]  sleep_state;
   logic        wr_en;
   logic [11:0] wr_data;
   logic [12:0] rd_word;
   logic        pad_oe, pad_out, irq_sts, wake_sts, pending, irq_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   gpio_pin_evt uut (
      .clk (clk), .rst_n (rst_n), .pin_in (pin_in), .sleep_state (sleep_state),
      .wr_en (wr_en), .wr_data (wr_data), .rd_word (rd_word),
      .pad_oe (pad_oe), .pad_out (pad_out), .irq_sts (irq_sts),
      .wake_sts (wake_sts), .pending (pending), .irq_out (irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // bit0 en, bit1 unmask, bit2 level, bits4:3 sel, bit5 oe, bit6 oval,
   // bits9:7 wake enables, bit10 clear irq, bit11 clear wake
   function automatic logic [11:0] mk(input bit en, input bit unm, input bit lvl,
                                      input logic [1:0] sel, input bit oe, input bit ov,
                                      input logic [2:0] wk, input bit ci, input bit cw);
      return {cw, ci, wk, ov, oe, sel, lvl, unm, en};
   endfunction

   task automatic wr(input logic [11:0] w);
      wr_en   = 1'b1;
      wr_data = w;
      tick();
      wr_en   = 1'b0;
   endtask

   task automatic setup(input logic [11:0] cfg, input bit p);
      pin_in = p;
      wr(cfg | 12'hC00);
      wr(cfg | 12'hC00);
   endtask

   task automatic t_reset();
      chk("R1 rd_word", rd_word, 13'h0);
      chk("R1 pad_oe", pad_oe, 0);
      chk("R1 pad_out", pad_out, 0);
      chk("R1 status", {irq_sts, wake_sts}, 0);
      chk("R1 pending/irq_out", {pending, irq_out}, 0);
   endtask

   task automatic t_config();
      wr(mk(1, 0, 1, 2'b10, 1, 1, 3'b101, 0, 0));
      chk("R2 pad_oe", pad_oe, 1);
      chk("R2 pad_out", pad_out, 1);
      chk("R2 readback", rd_word[9:0], 10'b101_11_10_1_0_1);
      wr(mk(0, 0, 0, 2'b00, 1, 0, 3'b000, 0, 0));
      chk("R2 pad_out low", {pad_oe, pad_out}, 2'b10);
   endtask

   task automatic t_edge();
      setup(mk(1, 1, 0, 2'b01, 0, 0, 3'b000, 0, 0), 0);
      chk("R3 clean start", irq_sts, 0);
      pin_in = 1; tick();
      chk("R3 rising sets", irq_sts, 1);
      chk("R9 delivered", irq_out, 1);
      chk("R11 pending", pending, 1);
      wr(mk(1, 1, 0, 2'b01, 0, 0, 3'b000, 1, 0));
      chk("R7 clear", irq_sts, 0);
      chk("R11 pending clear", pending, 0);
      pin_in = 0; tick();
      chk("R3 falling ignored", irq_sts, 0);
      setup(mk(1, 1, 0, 2'b00, 0, 0, 3'b000, 0, 0), 0);
      pin_in = 1; tick();
      chk("R3 rising ignored sel00", irq_sts, 0);
      pin_in = 0; tick();
      chk("R3 falling sets sel00", irq_sts, 1);
   endtask

   task automatic t_both();
      setup(mk(1, 1, 0, 2'b10, 0, 0, 3'b000, 0, 0), 0);
      pin_in = 1; tick();
      chk("R4 rise", irq_sts, 1);
      wr(mk(1, 1, 0, 2'b10, 0, 0, 3'b000, 1, 0));
      chk("R4 cleared", irq_sts, 0);
      pin_in = 0; tick();
      chk("R4 fall", irq_sts, 1);
   endtask

   task automatic t_rsvd();
      setup(mk(1, 1, 0, 2'b11, 0, 0, 3'b111, 0, 0), 0);
      sleep_state = 2'd1;
      pin_in = 1; tick();
      pin_in = 0; tick();
      chk("R5 edge sel11", {irq_sts, wake_sts}, 0);
      setup(mk(1, 1, 1, 2'b10, 0, 0, 3'b111, 0, 0), 1);
      tick();
      chk("R5 level sel10", {irq_sts, wake_sts}, 0);
      setup(mk(1, 1, 1, 2'b11, 0, 0, 3'b111, 0, 0), 1);
      tick();
      chk("R5 level sel11", {irq_sts, wake_sts}, 0);
      sleep_state = 2'd0;
   endtask

   task automatic t_level();
      setup(mk(1, 1, 1, 2'b01, 0, 0, 3'b000, 0, 0), 0);
      chk("R6 inactive", irq_sts, 0);
      pin_in = 1; tick();
      chk("R6 high sets", irq_sts, 1);
      wr(mk(1, 1, 1, 2'b01, 0, 0, 3'b000, 1, 0));
      chk("R6 clear while held", irq_sts, 1);
      pin_in = 0;
      wr(mk(1, 1, 1, 2'b01, 0, 0, 3'b000, 1, 0));
      chk("R6 clear after release", irq_sts, 0);
      setup(mk(1, 1, 1, 2'b00, 0, 0, 3'b000, 0, 0), 1);
      chk("R6 low inactive", irq_sts, 0);
      pin_in = 0; tick();
      chk("R6 low sets", irq_sts, 1);
   endtask

   task automatic t_race();
      setup(mk(1, 1, 0, 2'b01, 0, 0, 3'b000, 0, 0), 0);
      pin_in = 1; tick();
      pin_in = 0; tick();
      chk("R7 pre-race set", irq_sts, 1);
      pin_in = 1;
      wr(mk(1, 1, 0, 2'b01, 0, 0, 3'b000, 1, 0));
      chk("R7 clear with edge keeps", irq_sts, 1);
      wr(mk(1, 1, 0, 2'b01, 0, 0, 3'b000, 1, 0));
      chk("R7 clear alone", irq_sts, 0);
   endtask

   task automatic t_gate();
      setup(mk(0, 1, 0, 2'b01, 0, 0, 3'b000, 0, 0), 0);
      pin_in = 1; tick();
      chk("R8 disabled no status", irq_sts, 0);
      setup(mk(1, 0, 0, 2'b01, 0, 0, 3'b000, 0, 0), 0);
      pin_in = 1; tick();
      chk("R9 masked status", irq_sts, 1);
      chk("R9 masked no delivery", irq_out, 0);
      chk("R11 masked pending", pending, 1);
   endtask

   task automatic t_wake();
      setup(mk(0, 0, 0, 2'b01, 0, 0, 3'b010, 0, 0), 0);
      sleep_state = 2'd0;
      pin_in = 1; tick();
      chk("R10 running no wake", wake_sts, 0);
      pin_in = 0; tick();
      sleep_state = 2'd1;
      pin_in = 1; tick();
      chk("R10 other state no wake", wake_sts, 0);
      pin_in = 0; tick();
      sleep_state = 2'd2;
      pin_in = 1; tick();
      chk("R10 matched wake", wake_sts, 1);
      chk("R10 irq untouched", irq_sts, 0);
      chk("R11 wake pending", pending, 1);
      chk("R12 wake status bit", rd_word[11:10], 2'b10);
      wr(mk(0, 0, 0, 2'b01, 0, 0, 3'b010, 0, 1));
      chk("R7 wake clear", wake_sts, 0);
      sleep_state = 2'd0;
   endtask

   task automatic t_pin();
      pin_in = 1; #1;
      chk("R12 pin high", rd_word[12], 1);
      pin_in = 0; #1;
      chk("R12 pin low", rd_word[12], 0);
      tick();
   endtask

   initial begin
      rst_n = 1'b0; pin_in = 1'b0; sleep_state = 2'd0; wr_en = 1'b0; wr_data = '0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_config();
      t_edge();
      t_both();
      t_rsvd();
      t_level();
      t_race();
      t_gate();
      t_wake();
      t_pin();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule